// File: doc/BRIEF.md
# Paged Vector Read Sequencer

This block moves stored test vectors out of a memory bank and into the vector buffer on the tester's input side. It works one page at a time. It waits until the page is reported available. It then goes through a short opening step, an optional programmable start delay and a counter preload. After that it issues one read request per vector on a request/ready read port. The returned words, each flagged by a valid strobe, go into a small in-order holding queue. The queue drains into the downstream buffer whenever that buffer is not full.

A credit counter limits the reads in flight, so a full downstream buffer never causes a vector to be lost or repeated. When a page has been fully delivered, a decision step either reads the same page again from its first word or returns to idle. On the return to idle it raises a one-cycle completion pulse. The base address, page length and start delay are captured when the page is taken. The loop choice is read live at each decision.

Top module: `vec_page_reader`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_rd_req`, `buf_wr_en` and `seq_done` are all low.
- R2: In idle, no read request is issued for as long as `page_avail` is low. The sequencer leaves idle only on a clock edge where `page_avail` is high.
- R3: If `page_avail` is sampled high in idle at edge k, and D is the captured start delay, the first read request is visible in the cycle after edge k+2+D. A delay of 0 adds no wait cycles.
- R4: For each pass the accepted requests carry the addresses base, base+1, …, base+len−1 in that order. Exactly len requests are accepted per pass.
- R5: Every word returned by memory is written downstream exactly once and in request order, as one 96-bit vector per `buf_wr_en` cycle. Each pass delivers len vectors.
- R6: `buf_wr_en` is never high in a cycle where `buf_full` is high.
- R7: The number of accepted requests not yet written downstream never exceeds `SKID_DEPTH`. A request is withheld while that limit is reached.
- R8: While a request is pending and `mem_rd_ready` is low, `mem_rd_req` stays high and `mem_rd_addr` does not change on the next cycle.
- R9: With `cfg_loop` low at the decision step, `seq_done` pulses high for exactly one cycle, after the last vector of the page has been written. No pulse occurs while passes repeat.
- R10: With `cfg_loop` high at the decision step, the page is read again from its base address without a new `page_avail`, and the start delay is applied again.
- R11: `cfg_page_len` holds the vector count N directly, with 1 ≤ N ≤ `MAX_LEN` (1024 by default). N=1 and N=1024 both work. Base, length and delay are captured on leaving idle, and later changes to them do not affect the page in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_addr | input | ADDR_W | First word address of the page |
| cfg_page_len | input | LEN_W | Vectors per page (1..MAX_LEN) |
| cfg_start_dly | input | DLY_W | Wait cycles before the burst, 0 = none |
| cfg_loop | input | 1 | Repeat the page at the decision step |
| page_avail | input | 1 | Source page is ready to be read |
| mem_rd_req | output | 1 | Read request |
| mem_rd_addr | output | ADDR_W | Read word address |
| mem_rd_ready | input | 1 | Memory accepts the request this cycle |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | VEC_W | Read data word |
| buf_wr_en | output | 1 | Push one vector downstream |
| buf_wr_data | output | VEC_W | Vector pushed downstream |
| buf_full | input | 1 | Downstream buffer cannot take a vector |
| seq_done | output | 1 | One-cycle pulse on return to idle |

## Verification
The assertions assume that memory returns exactly one valid word per accepted request, in request order, no earlier than the cycle after acceptance. They also assume that `cfg_page_len` stays within 1..MAX_LEN whenever a page can be taken. The bench memory model meets these assumptions by design: it uses a fixed two-stage pipeline keyed only on accepted requests, and every swept length is drawn from the legal range. Ready and full are toggled only between clock edges, in always-on, periodic and pseudo-random patterns. The downstream model takes a vector on any cycle where full is low, which matches what the block expects of its consumer.

// File: rtl/vpr_pkg.sv
package vpr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPEN,
      ST_DELAY,
      ST_INIT,
      ST_BURST,
      ST_FINISH,
      ST_NEXT
   } seq_state_e;

   function automatic int cnt_width(input int max_val);
      return $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/vpr_skid_fifo.sv
module vpr_skid_fifo #(
   parameter int W     = 96,
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     push_data,
   input  logic             pop,
   output logic [W-1:0]     pop_data,
   output logic             empty,
   output logic [CNT_W-1:0] count
);

   logic [W-1:0]     store_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt_q;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr_q + PTR_W'(1);
         assign rd_nxt = rd_ptr_q + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
         assign rd_nxt = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) store_q[wr_ptr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push) wr_ptr_q <= wr_nxt;
         if (pop)  rd_ptr_q <= rd_nxt;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign pop_data = store_q[rd_ptr_q];
   assign empty    = (cnt_q == '0);
   assign count    = cnt_q;

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt_q < CNT_W'(DEPTH)));

   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cnt_q != '0));

endmodule

// File: rtl/vpr_credit.sv
module vpr_credit #(
   parameter int DEPTH = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic             retire,
   input  logic [CNT_W-1:0] fifo_count,
   output logic             credit_ok,
   output logic             drained
);

   logic [CNT_W-1:0] outst_q;
   logic [CNT_W:0]   in_flight;

   assign in_flight = {1'b0, outst_q} + {1'b0, fifo_count};
   assign credit_ok = (in_flight < (CNT_W + 1)'(DEPTH));
   assign drained   = (in_flight == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outst_q <= '0;
      end else begin
         case ({issue, retire})
            2'b10:   outst_q <= outst_q + CNT_W'(1);
            2'b01:   outst_q <= outst_q - CNT_W'(1);
            default: outst_q <= outst_q;
         endcase
      end
   end

   assert_credit_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_flight <= (CNT_W + 1)'(DEPTH));

   assert_retire_has_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
      retire |-> (outst_q != '0));

endmodule

// File: rtl/vpr_ctrl.sv
module vpr_ctrl
   import vpr_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 11,
   parameter int DLY_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base_addr,
   input  logic [LEN_W-1:0]  cfg_page_len,
   input  logic [DLY_W-1:0]  cfg_start_dly,
   input  logic              cfg_loop,
   input  logic              page_avail,
   input  logic              credit_ok,
   input  logic              drained,
   input  logic              rd_ready,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              done
);

   seq_state_e        state_q;
   logic [ADDR_W-1:0] base_q, addr_q;
   logic [LEN_W-1:0]  len_q, left_q;
   logic [DLY_W-1:0]  dly_cfg_q, dly_q;
   logic              done_q;
   logic              fire;

   assign rd_req  = (state_q == ST_BURST) && credit_ok;
   assign fire    = rd_req && rd_ready;
   assign rd_addr = addr_q;
   assign done    = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         base_q    <= '0;
         addr_q    <= '0;
         len_q     <= '0;
         left_q    <= '0;
         dly_cfg_q <= '0;
         dly_q     <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (page_avail) begin
                  base_q    <= cfg_base_addr;
                  len_q     <= cfg_page_len;
                  dly_cfg_q <= cfg_start_dly;
                  state_q   <= ST_OPEN;
               end
            end
            ST_OPEN: begin
               if (dly_cfg_q == '0) begin
                  state_q <= ST_INIT;
               end else begin
                  dly_q   <= dly_cfg_q;
                  state_q <= ST_DELAY;
               end
            end
            ST_DELAY: begin
               if (dly_q == DLY_W'(1)) state_q <= ST_INIT;
               else                    dly_q   <= dly_q - DLY_W'(1);
            end
            ST_INIT: begin
               addr_q  <= base_q;
               left_q  <= len_q;
               state_q <= ST_BURST;
            end
            ST_BURST: begin
               if (fire) begin
                  addr_q <= addr_q + ADDR_W'(1);
                  left_q <= left_q - LEN_W'(1);
                  if (left_q == LEN_W'(1)) state_q <= ST_FINISH;
               end
            end
            ST_FINISH: begin
               if (drained) state_q <= ST_NEXT;
            end
            ST_NEXT: begin
               if (cfg_loop) begin
                  state_q <= ST_OPEN;
               end else begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assert_avail_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == ST_IDLE && state_q != ST_IDLE) |-> $past(page_avail));

   assert_burst_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BURST && $past(state_q) != ST_BURST) |-> ($past(state_q) == ST_INIT));

   assert_done_after_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> drained);

   assert_burst_count_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BURST) |-> (left_q != '0));

endmodule

// File: rtl/vec_page_reader.sv
module vec_page_reader
   import vpr_pkg::*;
#(
   parameter int VEC_W      = 96,
   parameter int ADDR_W     = 16,
   parameter int MAX_LEN    = 1024,
   parameter int DLY_W      = 8,
   parameter int SKID_DEPTH = 4,
   localparam int LEN_W     = cnt_width(MAX_LEN),
   localparam int CNT_W     = $clog2(SKID_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base_addr,
   input  logic [LEN_W-1:0]  cfg_page_len,
   input  logic [DLY_W-1:0]  cfg_start_dly,
   input  logic              cfg_loop,
   input  logic              page_avail,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_ready,
   input  logic              mem_rd_valid,
   input  logic [VEC_W-1:0]  mem_rd_data,
   output logic              buf_wr_en,
   output logic [VEC_W-1:0]  buf_wr_data,
   input  logic              buf_full,
   output logic              seq_done
);

   generate
      if (SKID_DEPTH < 2) begin : g_bad_depth
         $error("vec_page_reader: SKID_DEPTH must be at least 2");
      end
      if (MAX_LEN < 1) begin : g_bad_len
         $error("vec_page_reader: MAX_LEN must be at least 1");
      end
      if (VEC_W < 1 || ADDR_W < 1 || DLY_W < 1) begin : g_bad_width
         $error("vec_page_reader: widths must be positive");
      end
   endgenerate

   logic             credit_ok, drained, fifo_empty, fire;
   logic [CNT_W-1:0] fifo_count;

   assign fire      = mem_rd_req && mem_rd_ready;
   assign buf_wr_en = !fifo_empty && !buf_full;

   vpr_ctrl #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W),
      .DLY_W  (DLY_W)
   ) i_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_base_addr (cfg_base_addr),
      .cfg_page_len  (cfg_page_len),
      .cfg_start_dly (cfg_start_dly),
      .cfg_loop      (cfg_loop),
      .page_avail    (page_avail),
      .credit_ok     (credit_ok),
      .drained       (drained),
      .rd_ready      (mem_rd_ready),
      .rd_req        (mem_rd_req),
      .rd_addr       (mem_rd_addr),
      .done          (seq_done)
   );

   vpr_credit #(
      .DEPTH (SKID_DEPTH)
   ) i_credit (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (fire),
      .retire     (mem_rd_valid),
      .fifo_count (fifo_count),
      .credit_ok  (credit_ok),
      .drained    (drained)
   );

   vpr_skid_fifo #(
      .W     (VEC_W),
      .DEPTH (SKID_DEPTH)
   ) i_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (mem_rd_valid),
      .push_data (mem_rd_data),
      .pop       (buf_wr_en),
      .pop_data  (buf_wr_data),
      .empty     (fifo_empty),
      .count     (fifo_count)
   );

   assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_ready) |=> (mem_rd_req && $stable(mem_rd_addr)));

   assert_no_write_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full |-> !buf_wr_en);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);

   assert_legal_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
      page_avail |-> (cfg_page_len != '0 && cfg_page_len <= LEN_W'(MAX_LEN)));

endmodule

// File: tb/test_vec_page_reader.sv
`timescale 1ns/1ps
module test_vec_page_reader;

   localparam int VEC_W  = 96;
   localparam int ADDR_W = 16;
   localparam int MAXL   = 1024;
   localparam int DLY_W  = 8;
   localparam int SKID   = 4;
   localparam int LEN_W  = $clog2(MAXL + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] cfg_base_addr = '0;
   logic [LEN_W-1:0]  cfg_page_len = LEN_W'(1);
   logic [DLY_W-1:0]  cfg_start_dly = '0;
   logic              cfg_loop;
   logic              loop_req = 1'b0;
   logic              stop_loop = 1'b0;
   logic              page_avail = 1'b0;
   logic              mem_rd_req;
   logic [ADDR_W-1:0] mem_rd_addr;
   logic              mem_rd_ready = 1'b1;
   logic              mem_rd_valid;
   logic [VEC_W-1:0]  mem_rd_data;
   logic              buf_wr_en;
   logic [VEC_W-1:0]  buf_wr_data;
   logic              buf_full = 1'b0;
   logic              seq_done;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   int pattern  = 0;
   logic [15:0] lfsr = 16'hACE1;

   int run_base = 0, run_len = 1;
   int run_issued = 0, run_delivered = 0;
   int tot_issued = 0, tot_delivered = 0;
   int done_cnt = 0, req_cyc = 0;
   bit got_first = 1'b0, loop_run = 1'b0;

   assign cfg_loop = loop_req && !stop_loop;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   vec_page_reader #(
      .VEC_W (VEC_W), .ADDR_W (ADDR_W), .MAX_LEN (MAXL),
      .DLY_W (DLY_W), .SKID_DEPTH (SKID)
   ) i_vec_page_reader (
      .clk (clk), .rst_n (rst_n),
      .cfg_base_addr (cfg_base_addr), .cfg_page_len (cfg_page_len),
      .cfg_start_dly (cfg_start_dly), .cfg_loop (cfg_loop),
      .page_avail (page_avail),
      .mem_rd_req (mem_rd_req), .mem_rd_addr (mem_rd_addr),
      .mem_rd_ready (mem_rd_ready), .mem_rd_valid (mem_rd_valid),
      .mem_rd_data (mem_rd_data),
      .buf_wr_en (buf_wr_en), .buf_wr_data (buf_wr_data),
      .buf_full (buf_full), .seq_done (seq_done)
   );

   function automatic logic [VEC_W-1:0] vec_of(input logic [ADDR_W-1:0] a);
      logic [31:0] w;
      w = 32'(a);
      return {w * 32'h9E3779B1, ~w, w + 32'h5A5A0000};
   endfunction

   // Memory model: fixed two-stage, in-order return.
   logic              v1 = 1'b0, v2 = 1'b0;
   logic [ADDR_W-1:0] a1 = '0, a2 = '0;
   always @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0; v2 <= 1'b0;
      end else begin
         v1 <= mem_rd_req && mem_rd_ready;
         a1 <= mem_rd_addr;
         v2 <= v1;
         a2 <= a1;
      end
   end
   assign mem_rd_valid = v2;
   assign mem_rd_data  = vec_of(a2);

   // Ready / full patterns, changed away from the edge.
   always @(posedge clk) begin
      #1;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (pattern)
         0: begin mem_rd_ready = 1'b1; buf_full = 1'b0; end
         1: begin mem_rd_ready = cyc[0]; buf_full = cyc[1] & cyc[0]; end
         2: begin mem_rd_ready = lfsr[0] | lfsr[3]; buf_full = lfsr[5] & lfsr[2]; end
         default: begin mem_rd_ready = lfsr[1]; buf_full = lfsr[4] | lfsr[6]; end
      endcase
   end

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd_req && mem_rd_ready) begin
            logic [ADDR_W-1:0] ea;
            ea = ADDR_W'(run_base + (run_issued % run_len));
            chk(mem_rd_addr == ea, "R4 address order", 128'(mem_rd_addr), 128'(ea));
            run_issued++;
            tot_issued++;
         end
         if (mem_rd_req && !got_first) begin
            got_first = 1'b1;
            req_cyc   = cyc;
         end
         if (buf_wr_en) begin
            logic [VEC_W-1:0] ed;
            ed = vec_of(ADDR_W'(run_base + (run_delivered % run_len)));
            chk(!buf_full, "R6 write while full", 128'(buf_full), 128'(0));
            chk(buf_wr_data == ed, "R5 vector data", 128'(buf_wr_data), 128'(ed));
            run_delivered++;
            tot_delivered++;
            if (loop_run && run_delivered == run_len + 1) stop_loop = 1'b1;
         end
         if (tot_issued - tot_delivered > SKID)
            chk(1'b0, "R7 in-flight bound", 128'(tot_issued - tot_delivered), 128'(SKID));
         if (seq_done) begin
            int expd;
            expd = loop_run ? 2 * run_len : run_len;
            done_cnt++;
            chk(run_delivered == expd, "R9 done after last vector", 128'(run_delivered), 128'(expd));
         end
      end
   end

   task automatic run_page(input int base, input int len, input int dly, input bit lp, input int pat);
      int t;
      int raise_cyc;
      int expd;
      @(negedge clk); #1;
      pattern       = pat;
      run_base      = base;
      run_len       = len;
      run_issued    = 0;
      run_delivered = 0;
      got_first     = 1'b0;
      done_cnt      = 0;
      stop_loop     = 1'b0;
      loop_run      = lp;
      loop_req      = lp;
      cfg_base_addr = ADDR_W'(base);
      cfg_page_len  = LEN_W'(len);
      cfg_start_dly = DLY_W'(dly);
      page_avail    = 1'b1;
      raise_cyc     = cyc;
      t = 0;
      while (!got_first && t < 2000) begin @(negedge clk); #1; t++; end
      // R3: first request D+3 cycles after raising availability
      chk(got_first && (req_cyc - raise_cyc == dly + 3), "R3 start delay timing",
          128'(req_cyc - raise_cyc), 128'(dly + 3));
      page_avail = 1'b0;
      // R11: scribble over the configuration; captured values must rule
      cfg_base_addr = ADDR_W'(base + 16'h3000);
      cfg_page_len  = LEN_W'(1 + (len % 5));
      cfg_start_dly = DLY_W'(dly + 7);
      t = 0;
      while (done_cnt == 0 && t < 20000) begin @(negedge clk); #1; t++; end
      repeat (6) @(negedge clk);
      #1;
      expd = lp ? 2 * len : len;
      chk(done_cnt == 1, lp ? "R10 loop then single done R9" : "R9 single done pulse",
          128'(done_cnt), 128'(1));
      chk(run_issued == expd, "R4 request count R11", 128'(run_issued), 128'(expd));
      chk(run_delivered == expd, "R5 delivered count", 128'(run_delivered), 128'(expd));
      chk(!mem_rd_req && !buf_wr_en, "R2 quiet after done", 128'({mem_rd_req, buf_wr_en}), 128'(0));
      loop_req = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(!mem_rd_req && !buf_wr_en && !seq_done, "R1 outputs during reset",
          128'({mem_rd_req, buf_wr_en, seq_done}), 128'(0));
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!mem_rd_req && !buf_wr_en && !seq_done, "R1 outputs after reset",
          128'({mem_rd_req, buf_wr_en, seq_done}), 128'(0));
      repeat (20) @(negedge clk);
      #1;
      chk(!got_first && tot_issued == 0, "R2 idle without availability",
          128'(tot_issued), 128'(0));

      begin
         int lens [5] = '{1, 2, 3, 7, 16};
         int dlys [3] = '{0, 1, 4};
         for (int li = 0; li < 5; li++)
            for (int di = 0; di < 3; di++)
               run_page(16 * li + 100 * di, lens[li], dlys[di], 1'b0, (li + di) % 4);
      end
      run_page(16'hFFFE, 5, 2, 1'b0, 2);            // address wrap
      run_page(16'h0400, 2, 255, 1'b0, 0);          // largest delay
      run_page(16'h1000, MAXL, 1, 1'b0, 3);         // R11 longest page
      run_page(16'h2000, MAXL, 0, 1'b0, 0);         // R11 longest page, no stall
      run_page(16'h0200, 3, 2, 1'b1, 3);            // R10 loop
      run_page(16'h0300, 1, 0, 1'b1, 0);            // R10 loop single vector
      run_page(16'h0500, 6, 3, 1'b1, 1);            // R10 loop periodic stall

      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule